// File: doc/BRIEF.md
# Serial LCD Command/Data Write Framer

This block sends one byte at a time to a character or graphics LCD controller over a three-wire serial link that only writes: a serial clock, a serial data line and an active-high chip-select. The host offers an 8-bit value and a flag that marks it as a command or as display data, using a valid/ready handshake. The block turns that value into a 24-bit frame and shifts the frame out most significant bit first. Chip-select stays high around the whole frame.

A frame has three bytes. The first is a sync byte that tells the controller whether a command or data follows. The second holds the high nibble of the value in its upper four bits. The third holds the low nibble of the value in its upper four bits. The lower four bits of the second and third bytes are always zero.

Typical use is a small control engine that sends command 0x30, then 0x0C, then 0x01 to clear the screen. After that it sends a line start address (0x80, 0x90, 0x88 or 0x98), followed by 16 data bytes per text line. The bit period is set by a parameter that counts system clocks per half period of the serial clock.

Top module: `lcd_ser_framer`

## Requirements
- R1: After reset, ser_cs and ser_clk are low and in_ready is high.
- R2: in_ready is high only while no frame is in progress. When in_valid and in_ready are both high at a clock edge, the value is accepted. From the next cycle, in_ready is low and ser_cs is high.
- R3: The first byte of the frame is 0xF8 when in_is_data is 0 (command) and 0xFA when in_is_data is 1 (data).
- R4: The second byte of the frame is in_byte AND 0xF0.
- R5: The third byte of the frame is (in_byte shifted left by four) AND 0xF0.
- R6: The 24 frame bits go out MSB first. Each bit holds ser_clk low for HALF_CLKS clocks and then high for HALF_CLKS clocks. ser_dat changes only while ser_clk is low, never on the cycle ser_clk rises.
- R7: ser_clk is low whenever ser_cs is low. ser_cs falls HALF_CLKS clocks after the last falling edge of ser_clk.
- R8: After ser_cs falls, it stays low for HALF_CLKS clocks (at least one) before in_ready returns high. This holds even when in_valid is held high.
- R9: While a frame is in progress, changes on in_byte, in_is_data and in_valid have no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Block can accept a byte |
| in_byte | input | 8 | Value to send |
| in_is_data | input | 1 | 1 = display data, 0 = command |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_dat | output | 1 | Serial data, MSB first |
| ser_cs | output | 1 | Chip-select, active high |

## Verification
The embedded assertions check the following on every cycle:
- the serial clock stays low while chip-select is low;
- data does not move on a rising clock;
- chip-select falls only with the clock low;
- an accepted byte drops ready and raises chip-select;
- the phase counter stays within its range.

These checks cannot show that the frame content is right: the sync byte for command versus data, the nibble placement, the bit count and the exact phase lengths. The bench's cycle-accurate model and its serial receiver show those. They are tested over command and data values, all-ones and all-zeros bytes, and back-to-back frames with valid held high and the inputs changing during transmission.

// File: rtl/lcdsf_pkg.sv
package lcdsf_pkg;

  localparam int FRAME_BITS = 24;
  localparam logic [7:0] SYNC_CMD = 8'hF8;
  localparam logic [7:0] SYNC_DAT = 8'hFA;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_GAP
  } fr_state_e;

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] val,
                                                         input logic       is_data);
    logic [7:0] sync;
    sync = is_data ? SYNC_DAT : SYNC_CMD;
    return {sync, val[7:4], 4'h0, val[3:0], 4'h0};
  endfunction

endpackage

// File: rtl/lcdsf_phase_timer.sv
module lcdsf_phase_timer #(
  parameter int HALF_CLKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic done
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !run || done) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R6
  idle_cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/lcdsf_serializer.sv
module lcdsf_serializer
  import lcdsf_pkg::*;
#(
  parameter int NBITS = FRAME_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [NBITS-1:0] frame,
  input  logic             tick,
  output logic             run,
  output logic             accept,
  output logic             ready,
  output logic             sclk,
  output logic             sdat,
  output logic             cs
);
  localparam int BCW = $clog2(NBITS);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(NBITS - 1);

  fr_state_e        st_q, st_d;
  logic [NBITS-1:0] sh_q, sh_d;
  logic [BCW-1:0]   bits_q, bits_d;
  logic             sclk_q, sclk_d;
  logic             cs_q, cs_d;

  assign ready  = (st_q == ST_IDLE);
  assign accept = ready && start_req;
  assign run    = (st_q != ST_IDLE);
  assign sclk   = sclk_q;
  assign cs     = cs_q;
  assign sdat   = sh_q[NBITS-1];

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    bits_d = bits_q;
    sclk_d = sclk_q;
    cs_d   = cs_q;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        sh_d   = frame;
        bits_d = LAST_BIT;
        cs_d   = 1'b1;
        st_d   = ST_LOW;
      end
      ST_LOW: if (tick) begin
        sclk_d = 1'b1;
        st_d   = ST_HIGH;
      end
      ST_HIGH: if (tick) begin
        sclk_d = 1'b0;
        sh_d   = {sh_q[NBITS-2:0], 1'b0};
        if (bits_q == '0) begin
          st_d = ST_TAIL;
        end else begin
          bits_d = bits_q - 1'b1;
          st_d   = ST_LOW;
        end
      end
      ST_TAIL: if (tick) begin
        cs_d = 1'b0;
        st_d = ST_GAP;
      end
      ST_GAP: if (tick) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      bits_q <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      sh_q   <= sh_d;
      bits_q <= bits_d;
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
    end
  end

  // R7
  clk_low_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> !sclk_q);

  // R6
  data_steady_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(sdat));

  // R7
  cs_fall_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> !sclk_q && !$past(sclk_q));

  // R2
  accept_takes_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready && cs_q && !sclk_q);

  // R8
  ready_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_q) |-> !ready);

endmodule

// File: rtl/lcd_ser_framer.sv
module lcd_ser_framer
  import lcdsf_pkg::*;
#(
  parameter int HALF_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_is_data,
  output logic       ser_clk,
  output logic       ser_dat,
  output logic       ser_cs
);
  logic                  run, accept, tick;
  logic [FRAME_BITS-1:0] frame;

  assign frame = build_frame(in_byte, in_is_data);

  lcdsf_phase_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (accept),
    .done    (tick)
  );

  lcdsf_serializer #(.NBITS(FRAME_BITS)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (in_valid),
    .frame     (frame),
    .tick      (tick),
    .run       (run),
    .accept    (accept),
    .ready     (in_ready),
    .sclk      (ser_clk),
    .sdat      (ser_dat),
    .cs        (ser_cs)
  );

  // R1
  ready_only_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !ser_cs && !ser_clk);

endmodule

// File: tb/sim_lcd_ser_framer.sv
module sim_lcd_ser_framer;
  localparam int HALF = 3;
  localparam int FRAME_CYC = 50 * HALF;

  logic       clk, rst_n, in_valid, in_is_data;
  logic [7:0] in_byte;
  logic       in_ready, ser_clk, ser_dat, ser_cs;

  int total = 0;
  int bad   = 0;

  lcd_ser_framer #(.HALF_CLKS(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_data(in_is_data),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_cs(ser_cs)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [23:0] ref_frame(input logic [7:0] v, input logic d);
    logic [7:0] b0, b1, b2;
    b0 = d ? 8'hFA : 8'hF8;
    b1 = v & 8'hF0;
    b2 = (v << 4) & 8'hF0;
    return {b0, b1, b2};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle model: t = cycles since acceptance, -1 when idle
  int          t;
  logic [23:0] mframe;
  logic [23:0] exp_q[$];
  int          nframes;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t = -1;
      mframe = '0;
    end else if (t < 0) begin
      if (in_valid) begin
        mframe = ref_frame(in_byte, in_is_data);
        exp_q.push_back(mframe);
        t = 0;
      end
    end else begin
      t = t + 1;
      if (t == FRAME_CYC) t = -1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic ecs, eclk, edat, erdy;
      int p;
      if (t < 0) begin
        ecs = 0; eclk = 0; edat = 0; erdy = 1;
      end else begin
        p = t / HALF;
        erdy = 0;
        ecs  = (p < 49);
        eclk = (p < 48) && (p % 2 == 1);
        edat = (p < 48) ? mframe[23 - p/2] : 1'b0;
      end
      chk(in_ready == erdy, "R2 ready", in_ready, erdy);
      chk(ser_cs == ecs, "R7/R8 cs", ser_cs, ecs);
      chk(ser_clk == eclk, "R6 clk", ser_clk, eclk);
      chk(ser_dat == edat, "R6 dat", ser_dat, edat);
    end
  end

  // serial receiver
  logic [23:0] rx;
  int          nbits;
  always @(posedge ser_clk) begin
    rx = {rx[22:0], ser_dat};
    nbits++;
  end
  always @(posedge ser_cs) begin
    rx = '0;
    nbits = 0;
  end
  always @(negedge ser_cs) begin
    if (rst_n) begin
      logic [23:0] e;
      if (exp_q.size() == 0) begin
        chk(0, "R2 unexpected frame", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk(nbits == 24, "R6 bit count", nbits, 24);
        chk(rx[23:16] == e[23:16], "R3 sync byte", rx[23:16], e[23:16]);
        chk(rx[15:8] == e[15:8], "R4 high nibble byte", rx[15:8], e[15:8]);
        chk(rx[7:0] == e[7:0], "R5 low nibble byte", rx[7:0], e[7:0]);
        nframes++;
      end
    end
  end

  task automatic send(input logic [7:0] v, input logic d);
    @(negedge clk);
    in_valid = 1'b1; in_byte = v; in_is_data = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic drop_and_wait(input logic [7:0] junk);
    @(negedge clk);
    in_valid = 1'b0; in_byte = junk; in_is_data = ~in_is_data; // R9
    repeat (FRAME_CYC / 2) @(negedge clk);
    in_byte = ~junk;
    while (!in_ready) @(negedge clk);
  endtask

  int cyc;
  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        chk(0, "watchdog", cyc, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    nframes = 0; nbits = 0; rx = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; in_is_data = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ser_cs == 0, "R1 cs", ser_cs, 0);
    chk(ser_clk == 0, "R1 clk", ser_clk, 0);
    chk(in_ready == 1, "R1 ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    // commands: init, display on, clear, line addresses
    send(8'h30, 1'b0); drop_and_wait(8'h5A);
    send(8'h0C, 1'b0); drop_and_wait(8'hA5);
    send(8'h01, 1'b0); drop_and_wait(8'h3C);
    // back-to-back with valid held (R8, R9)
    send(8'h80, 1'b0);
    send(8'h90, 1'b0);
    send(8'h88, 1'b0);
    send(8'h98, 1'b0);
    // data patterns
    send(8'h41, 1'b1);
    send(8'hFF, 1'b1);
    send(8'h00, 1'b1);
    send(8'hA5, 1'b0);
    drop_and_wait(8'hC3);
    repeat (5) @(negedge clk);
    // R9: all frames received with accepted values only
    chk(nframes == 11, "R9 frame count", nframes, 11);
    chk(exp_q.size() == 0, "R9 pending frames", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule